// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter with Wait Timeout

This block decides which of several DMA channels may use the shared system bus. Each channel raises a request line and carries a 2-bit software priority. The arbiter grants the bus to one channel at a time. A grant lasts until the served channel reports that its data unit is finished. Only then is priority evaluated again, so a more urgent request never cuts a unit short.

Alongside the grant, the arbiter drives a high-priority bus request to the processor core. A programmable timeout of up to 63 cycles holds this request back. The count starts from the cycle in which the most recent channel request appeared. A timeout of zero sends the request in the same cycle. A global enable gates all new grants. A status word shows the enable, a busy flag and the timeout field. The timeout field can only be loaded while the arbiter is both disabled and idle. A registered per-channel interrupt summary collects the channels' event lines into one place.

Top module: `dma_bus_arbiter`

## Requirements
- R1: At most one bit of `gnt` is set at any time. A grant only goes to a channel whose request was high, with `glb_en` high, in the cycle before the grant appears.
- R2: Among the requesting channels, the one with the highest priority is granted. Channel i's priority is `ch_prio[2i+1:2i]`, with 0 = low, 1 = medium, 2 = high and 3 = very high.
- R3: When two or more requesting channels share the highest priority, the lowest-numbered of them is granted.
- R4: A grant stays unchanged until `ch_done` is high for the granted channel at a clock edge. The arbiter ignores higher-priority requests and `ch_done` on other channels in the meantime. At that edge it arbitrates again, and the new grant (or none) is visible in the next cycle.
- R5: While `glb_en` is low, no new grant is issued. A grant already in progress is held until its unit ends.
- R6: `busy` is high exactly while a grant is held. The status word `ctrl_stat` places the enable at bit 0, busy at bit 1 and the timeout at bits 7:2. It reads 0 after reset.
- R7: A timeout write (`tmo_wr` with `tmo_wdata`) takes effect at the next edge only if `glb_en` and `busy` are both low. Otherwise the stored timeout does not change.
- R8: With a timeout T greater than 0, `hp_req` first rises T cycles after the cycle in which the most recent new request appeared. It then stays high while any enabled request is pending, up to the maximum of 63.
- R9: With a timeout of 0, `hp_req` is high in the same cycle as a new request.
- R10: A request that rises on another channel while others are pending restarts the wait count.
- R11: While no enabled request is pending, `hp_req` is low.
- R12: `irq_sum` shows each channel's `ch_irq` line one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable for all channels |
| tmo_wr | input | 1 | Timeout write strobe |
| tmo_wdata | input | 6 | Timeout value to write |
| ch_req | input | 4 | Per-channel bus request |
| ch_prio | input | 8 | Packed 2-bit priorities, channel 0 in the low bits |
| ch_done | input | 4 | Per-channel end of data unit |
| ch_irq | input | 4 | Per-channel interrupt event line |
| gnt | output | 4 | One-hot bus grant |
| busy | output | 1 | A grant is held |
| hp_req | output | 1 | High-priority bus request to the core |
| ctrl_stat | output | 8 | Status word: timeout, busy, enable |
| irq_sum | output | 4 | Registered interrupt summary |

## Verification
The bench builds the block with its defaults: four channels, 2-bit priorities and a 6-bit timeout. These defaults let every priority level be placed on a different channel at once. They also let the wait counter be driven to its 63-cycle ceiling, where the saturation edge is visible. Timeouts of 0, 1, 5 and 63 exercise the immediate, shortest, mid-range and maximum waits. A mid-wait second request shows the restart of the count.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
  // Software priority levels; a larger code wins.
  typedef enum logic [1:0] {
    PRIO_LOW   = 2'd0,
    PRIO_MED   = 2'd1,
    PRIO_HIGH  = 2'd2,
    PRIO_VHIGH = 2'd3
  } prio_lvl_e;

  // Status word layout: enable, busy, then the timeout field.
  localparam int STAT_EN_BIT   = 0;
  localparam int STAT_BUSY_BIT = 1;
  localparam int STAT_TMO_LSB  = 2;
endpackage

// File: rtl/dmaarb_pick.sv
module dmaarb_pick #(
  parameter int NUM_CH = 4,
  parameter int PRIO_W = 2,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0]        req,
  input  logic [NUM_CH*PRIO_W-1:0] prio,
  output logic                     any,
  output logic [IDX_W-1:0]         win_idx
);
  logic [PRIO_W-1:0] best_pr;

  // Scan upward; strictly-greater keeps the lowest index on ties (R3).
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    best_pr = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req[i] && (!any || prio[i*PRIO_W +: PRIO_W] > best_pr)) begin
        any     = 1'b1;
        win_idx = IDX_W'(i);
        best_pr = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/dmaarb_wait_timer.sv
module dmaarb_wait_timer #(
  parameter int NUM_CH = 4,
  parameter int TMO_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_vec,
  input  logic [TMO_W-1:0]  tmo,
  output logic              hp_req
);
  localparam logic [TMO_W-1:0] WMAX = '1;

  logic [NUM_CH-1:0] req_d, req_d_nx;
  logic [TMO_W-1:0]  wait_q, wait_d;
  logic              pend, req_new;

  assign pend    = |req_vec;
  assign req_new = |(req_vec & ~req_d);

  always_comb begin
    req_d_nx = req_vec;
    wait_d   = wait_q;
    if (!pend)                wait_d = '0;
    else if (req_new)         wait_d = TMO_W'(1);
    else if (wait_q != WMAX)  wait_d = wait_q + TMO_W'(1);
  end

  assign hp_req = pend & (req_new ? (tmo == '0) : (wait_q >= tmo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d  <= '0;
      wait_q <= '0;
    end else begin
      req_d  <= req_d_nx;
      wait_q <= wait_d;
    end
  end

  // R11: nothing pending, no urgent bus request
  p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> !hp_req);
  // R10: a newly rising request restarts the count at one
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && req_new) |=> (wait_q == TMO_W'(1)));
  // R8: the count saturates instead of wrapping
  p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !req_new && wait_q == WMAX) |=> (wait_q == WMAX));
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dmaarb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PRIO_W = 2,
  parameter int TMO_W  = 6,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int STAT_W = TMO_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     glb_en,
  input  logic                     tmo_wr,
  input  logic [TMO_W-1:0]         tmo_wdata,
  input  logic [NUM_CH-1:0]        ch_req,
  input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
  input  logic [NUM_CH-1:0]        ch_done,
  input  logic [NUM_CH-1:0]        ch_irq,
  output logic [NUM_CH-1:0]        gnt,
  output logic                     busy,
  output logic                     hp_req,
  output logic [STAT_W-1:0]        ctrl_stat,
  output logic [NUM_CH-1:0]        irq_sum
);
  logic [NUM_CH-1:0] req_en;
  logic [NUM_CH-1:0] gnt_q, gnt_d;
  logic [NUM_CH-1:0] irq_q;
  logic [TMO_W-1:0]  tmo_q, tmo_d;
  logic              any_req, unit_end, tmo_we;
  logic [IDX_W-1:0]  win_idx;

  assign req_en = ch_req & {NUM_CH{glb_en}};

  dmaarb_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_pick (
    .req     (req_en),
    .prio    (ch_prio),
    .any     (any_req),
    .win_idx (win_idx)
  );

  dmaarb_wait_timer #(.NUM_CH(NUM_CH), .TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_vec (req_en),
    .tmo     (tmo_q),
    .hp_req  (hp_req)
  );

  assign unit_end = |(ch_done & gnt_q);
  assign busy     = |gnt_q;
  assign tmo_we   = tmo_wr & ~glb_en & ~busy;

  // Grant next state: re-arbitrate only when idle or at the end of a unit.
  always_comb begin
    gnt_d = gnt_q;
    if (gnt_q == '0 || unit_end)
      gnt_d = any_req ? (NUM_CH'(1) << win_idx) : '0;
  end

  always_comb begin
    tmo_d = tmo_we ? tmo_wdata : tmo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
      tmo_q <= '0;
      irq_q <= '0;
    end else begin
      gnt_q <= gnt_d;
      tmo_q <= tmo_d;
      irq_q <= ch_irq;
    end
  end

  always_comb begin
    ctrl_stat                                = '0;
    ctrl_stat[STAT_EN_BIT]                   = glb_en;
    ctrl_stat[STAT_BUSY_BIT]                 = busy;
    ctrl_stat[STAT_TMO_LSB +: TMO_W]         = tmo_q;
  end

  assign gnt     = gnt_q;
  assign irq_sum = irq_q;

  // R1: grant vector is one-hot or empty
  p_gnt_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));
  // R1: a fresh grant lands on a channel that was requesting while enabled
  p_gnt_to_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != '0 && !$stable(gnt_q)) |-> (|($past(req_en) & gnt_q)));
  // R4: grant held until the served channel finishes its unit
  p_hold_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != '0 && !unit_end) |=> $stable(gnt_q));
  // R5: disabled and idle stays idle
  p_no_grant_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q == '0 && !glb_en) |=> (gnt_q == '0));
  // R7: timeout frozen while enabled or busy
  p_tmo_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en || busy) |=> $stable(tmo_q));
  // R12: summary follows the event lines by one cycle
  p_irq_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q == $past(ch_irq)));
endmodule

// File: tb/test_dma_bus_arbiter.sv
module test_dma_bus_arbiter;
  import dmaarb_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       glb_en, tmo_wr;
  logic [5:0] tmo_wdata;
  logic [3:0] ch_req, ch_done, ch_irq;
  logic [7:0] ch_prio;
  logic [3:0] gnt, irq_sum;
  logic       busy, hp_req;
  logic [7:0] ctrl_stat;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dma_bus_arbiter i_dma_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .tmo_wr(tmo_wr),
    .tmo_wdata(tmo_wdata), .ch_req(ch_req), .ch_prio(ch_prio),
    .ch_done(ch_done), .ch_irq(ch_irq), .gnt(gnt), .busy(busy),
    .hp_req(hp_req), .ctrl_stat(ctrl_stat), .irq_sum(irq_sum)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_prio(input int ch, input prio_lvl_e p);
    ch_prio[ch*2 +: 2] = p;
  endtask

  task automatic go_idle();
    ch_req  = '0;
    glb_en  = 1'b0;
    ch_done = '1;
    @(negedge clk);
    ch_done = '0;
    @(negedge clk);
  endtask

  task automatic write_tmo(input logic [5:0] v);
    tmo_wr = 1'b1; tmo_wdata = v;
    @(negedge clk);
    tmo_wr = 1'b0;
  endtask

  task automatic end_unit(input int ch);
    ch_done[ch] = 1'b1;
    ch_req[ch]  = 1'b0;
    @(negedge clk);
    ch_done = '0;
  endtask

  task automatic t_reset();
    check("R6 reset gnt", gnt, 0);
    check("R6 reset busy", busy, 0);
    check("R6 reset status", ctrl_stat, 0);
    check("R11 reset hp_req", hp_req, 0);
    check("R12 reset irq_sum", irq_sum, 0);
  endtask

  task automatic t_priority();
    go_idle();
    glb_en = 1'b1;
    set_prio(0, PRIO_LOW); set_prio(1, PRIO_HIGH);
    set_prio(2, PRIO_VHIGH); set_prio(3, PRIO_MED);
    ch_req = 4'b1111;
    @(negedge clk);
    check("R2 very high wins", gnt, 4'b0100);
    check("R6 busy with grant", ctrl_stat[1:0], 2'b11);
    end_unit(2);
    check("R2 high next", gnt, 4'b0010);
    end_unit(1);
    check("R2 medium next", gnt, 4'b1000);
    end_unit(3);
    check("R2 low last", gnt, 4'b0001);
    end_unit(0);
    check("R1 no request no grant", gnt, 0);
    check("R6 busy clear", busy, 0);
  endtask

  task automatic t_tie();
    go_idle();
    glb_en = 1'b1;
    set_prio(0, PRIO_MED); set_prio(1, PRIO_HIGH);
    set_prio(2, PRIO_LOW); set_prio(3, PRIO_HIGH);
    ch_req = 4'b1011;
    @(negedge clk);
    check("R3 tie lowest index", gnt, 4'b0010);
    end_unit(1);
    check("R3 tie partner next", gnt, 4'b1000);
  endtask

  task automatic t_hold();
    go_idle();
    glb_en = 1'b1;
    set_prio(0, PRIO_VHIGH); set_prio(1, PRIO_LOW);
    ch_req = 4'b0010;
    @(negedge clk);
    check("R1 single request granted", gnt, 4'b0010);
    ch_req[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 grant held against higher priority", gnt, 4'b0010);
    ch_done[0] = 1'b1;
    @(negedge clk);
    ch_done = '0;
    check("R4 done of other channel ignored", gnt, 4'b0010);
    end_unit(1);
    check("R4 rearbitrate at unit end", gnt, 4'b0001);
  endtask

  task automatic t_lock();
    go_idle();
    write_tmo(6'd5);
    check("R7 write while idle and disabled", ctrl_stat[7:2], 5);
    glb_en = 1'b1;
    @(negedge clk);
    write_tmo(6'd9);
    check("R7 write ignored while enabled", ctrl_stat[7:2], 5);
    ch_req = 4'b0100;
    @(negedge clk);
    check("R1 grant before disable", gnt, 4'b0100);
    glb_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 grant held while disabled", gnt, 4'b0100);
    check("R6 status busy not enabled", ctrl_stat[1:0], 2'b10);
    write_tmo(6'd12);
    check("R7 write ignored while busy", ctrl_stat[7:2], 5);
    ch_req[0] = 1'b1;
    end_unit(2);
    check("R5 no new grant while disabled", gnt, 0);
    write_tmo(6'd12);
    check("R7 write accepted again", ctrl_stat[7:2], 12);
  endtask

  task automatic t_timeout(input int t);
    go_idle();
    write_tmo(6'(t));
    glb_en = 1'b1;
    @(negedge clk);
    ch_req = 4'b0001;
    #1;
    if (t == 0) check("R9 zero timeout immediate", hp_req, 1);
    else        check("R8 low in request cycle", hp_req, 0);
    for (int j = 1; j <= t + 4; j++) begin
      @(negedge clk);
      #1;
      if (j == t - 1) check("R8 low one cycle early", hp_req, 0);
      if (j == t)     check("R8 rises after timeout", hp_req, 1);
      if (j == t + 4) check("R8 stays high while pending", hp_req, 1);
    end
    ch_req = '0;
    #1;
    check("R11 low when nothing pending", hp_req, 0);
  endtask

  task automatic t_restart();
    go_idle();
    write_tmo(6'd5);
    glb_en = 1'b1;
    @(negedge clk);
    ch_req = 4'b0001;
    repeat (3) @(negedge clk);
    ch_req[3] = 1'b1;
    for (int j = 1; j <= 5; j++) begin
      @(negedge clk);
      #1;
      if (j == 4) check("R10 restart keeps low past first deadline", hp_req, 0);
      if (j == 5) check("R10 rises after restarted wait", hp_req, 1);
    end
  endtask

  task automatic t_irq();
    ch_irq = 4'b1010;
    #1;
    check("R12 summary not yet updated", irq_sum, 0);
    @(negedge clk);
    check("R12 summary captured", irq_sum, 4'b1010);
    ch_irq = 4'b0101;
    @(negedge clk);
    check("R12 summary follows", irq_sum, 4'b0101);
  endtask

  initial begin
    rst_n = 1'b0; glb_en = 1'b0; tmo_wr = 1'b0; tmo_wdata = '0;
    ch_req = '0; ch_done = '0; ch_irq = '0; ch_prio = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_priority();
    t_tie();
    t_hold();
    t_lock();
    t_timeout(0);
    t_timeout(1);
    t_timeout(5);
    t_timeout(63);
    t_restart();
    t_irq();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule